// File: doc/BRIEF.md
# Accumulator ALU with Carry Register

This block is the arithmetic and logic unit of a small 8-bit datapath. It combines an accumulator value with one operand. A multiplexer outside the block picks that operand from a register, an immediate or memory. The unit returns three things: a result, a result-write enable, and a next-carry value with its own carry-write enable. A single carry flag is the only flag the block models, and its register sits inside the block.

The arithmetic is purely combinational from the accumulator, the operand, the opcode and the current carry. When `op_valid` is high, the carry register loads the next-carry value at the rising clock edge, but only if the selected operation writes carry. The result itself is returned to the caller, which writes it to the accumulator or to memory while `res_we` is high. Increment and decrement work on the operand, so a caller can apply them to any register or memory byte without disturbing carry.

Opcodes, as a 4-bit `op_code`: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 compare, 6 complement accumulator, 7 increment operand, 8 decrement operand, 9 invert carry, 10 set carry. Codes 11 to 15 are unused.

Top module: `acc_alu_unit`

## Requirements
- R1: Add (code 0) gives (acc + opnd) mod 256 and next carry 1 exactly when the 9-bit sum exceeds 255. Add with carry (code 1) adds the current carry as well. Plain add ignores the current carry.
- R2: Subtract (code 2) gives (acc - opnd) mod 256 and next carry 1 exactly when acc - opnd is negative. Subtract with borrow (code 3) also subtracts the current carry.
- R3: AND (code 4) gives acc & opnd and next carry 0.
- R4: Compare (code 5) writes no result. Its next carry is 1 exactly when acc < opnd, compared unsigned.
- R5: Complement (code 6) gives acc XOR 0xFF and does not write carry.
- R6: Increment (code 7) and decrement (code 8) give (opnd + 1) mod 256 and (opnd - 1) mod 256, and do not write carry.
- R7: Invert carry (code 9) gives next carry equal to NOT current carry. Set carry (code 10) gives next carry 1. Neither writes a result.
- R8: The carry register reads 0 after reset. It changes only at a rising edge where `carry_we` is high, and it then takes `carry_nxt`.
- R9: With `op_valid` high, `res_we` is 1 for codes 0-4 and 6-8, and `carry_we` is 1 for codes 0-5, 9 and 10. Codes 11-15, or `op_valid` low, leave both enables at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the carry register |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 4 | Operation select |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Operand value, selected outside the block |
| res_out | output | 8 | Result value |
| res_we | output | 1 | Result write enable |
| carry_nxt | output | 1 | Carry value to be written |
| carry_we | output | 1 | Carry write enable |
| carry_q | output | 1 | Current carry flag |

## Verification
Every opcode, including the unused ones, is swept over all 256 accumulator values against 32 operand values at both ends of the range. The sweep runs once with carry clear and once with carry set. The extreme operands expose wrap and borrow boundaries. Running both carry states separates the carry-consuming operations (add with carry, subtract with borrow, invert carry) from the ones that must ignore carry.

A second pass issues each opcode with `op_valid` high from both carry states and reads `carry_q` after the edge. This shows which operations really write carry: compare must change carry, while complement, increment, decrement and the unused codes must leave it as it was.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_AND = 4'd4,
      OP_CMP = 4'd5,
      OP_CPL = 4'd6,
      OP_INC = 4'd7,
      OP_DEC = 4'd8,
      OP_CCF = 4'd9,
      OP_SCF = 4'd10
   } alu_op_e;

   typedef struct packed {
      logic wr_res;
      logic wr_cy;
      logic sub;
      logic use_cin;
   } alu_ctl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
(
   input  logic [3:0] op_code,
   output alu_ctl_t   ctl
);

   always_comb begin
      ctl = '0;
      case (op_code)
         OP_ADD: begin ctl.wr_res = 1'b1; ctl.wr_cy = 1'b1; end
         OP_ADC: begin ctl.wr_res = 1'b1; ctl.wr_cy = 1'b1; ctl.use_cin = 1'b1; end
         OP_SUB: begin ctl.wr_res = 1'b1; ctl.wr_cy = 1'b1; ctl.sub = 1'b1; end
         OP_SBC: begin ctl.wr_res = 1'b1; ctl.wr_cy = 1'b1; ctl.sub = 1'b1; ctl.use_cin = 1'b1; end
         OP_AND: begin ctl.wr_res = 1'b1; ctl.wr_cy = 1'b1; end
         OP_CMP: begin ctl.wr_cy  = 1'b1; ctl.sub = 1'b1; end
         OP_CPL,
         OP_INC,
         OP_DEC: ctl.wr_res = 1'b1;
         OP_CCF,
         OP_SCF: ctl.wr_cy  = 1'b1;
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int WIDTH       = 8,
   parameter bit ADDER_FUSED = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   localparam int EXT = WIDTH + 1;

   logic [EXT-1:0] wide;

   generate
      if (ADDER_FUSED) begin : g_fused
         // one carry chain: a + ~b + ~borrow, carry out inverted for subtract
         logic [WIDTH-1:0] b_x;
         assign b_x  = b ^ {WIDTH{sub}};
         assign wide = {1'b0, a} + {1'b0, b_x} + {{WIDTH{1'b0}}, cin ^ sub};
         assign cout = wide[WIDTH] ^ sub;
      end else begin : g_split
         logic [EXT-1:0] w_add;
         logic [EXT-1:0] w_sub;
         assign w_add = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
         assign w_sub = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cin};
         assign wide  = sub ? w_sub : w_add;
         assign cout  = wide[WIDTH];
      end
   endgenerate

   assign sum = wide[WIDTH-1:0];

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
   import acc_alu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit ADDER_FUSED = 1'b1
) (
   input  logic [3:0]       op_code,
   input  alu_ctl_t         ctl,
   input  logic [WIDTH-1:0] acc,
   input  logic [WIDTH-1:0] opnd,
   input  logic             cy,
   output logic [WIDTH-1:0] res,
   output logic             cy_nxt
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [WIDTH-1:0] as_sum;
   logic             as_cout;

   acc_alu_addsub #(
      .WIDTH       (WIDTH),
      .ADDER_FUSED (ADDER_FUSED)
   ) u_addsub (
      .a    (acc),
      .b    (opnd),
      .sub  (ctl.sub),
      .cin  (ctl.use_cin & cy),
      .sum  (as_sum),
      .cout (as_cout)
   );

   always_comb begin
      res    = acc;
      cy_nxt = cy;
      case (op_code)
         OP_ADD, OP_ADC,
         OP_SUB, OP_SBC: begin res = as_sum; cy_nxt = as_cout; end
         OP_AND: begin res = acc & opnd; cy_nxt = 1'b0; end
         OP_CMP: cy_nxt = as_cout;
         OP_CPL: res = ~acc;
         OP_INC: res = opnd + ONE;
         OP_DEC: res = opnd - ONE;
         OP_CCF: cy_nxt = ~cy;
         OP_SCF: cy_nxt = 1'b1;
         default: begin res = acc; cy_nxt = cy; end
      endcase
   end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
   import acc_alu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit ADDER_FUSED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] acc_in,
   input  logic [WIDTH-1:0] opnd_in,
   output logic [WIDTH-1:0] res_out,
   output logic             res_we,
   output logic             carry_nxt,
   output logic             carry_we,
   output logic             carry_q
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("acc_alu_unit: WIDTH must be at least 2");
      end
   endgenerate

   alu_ctl_t ctl;

   acc_alu_decode u_decode (
      .op_code (op_code),
      .ctl     (ctl)
   );

   acc_alu_datapath #(
      .WIDTH       (WIDTH),
      .ADDER_FUSED (ADDER_FUSED)
   ) u_datapath (
      .op_code (op_code),
      .ctl     (ctl),
      .acc     (acc_in),
      .opnd    (opnd_in),
      .cy      (carry_q),
      .res     (res_out),
      .cy_nxt  (carry_nxt)
   );

   assign res_we   = op_valid & ctl.wr_res;
   assign carry_we = op_valid & ctl.wr_cy;

   always_ff @(posedge clk) begin
      if (!rst_n)        carry_q <= 1'b0;
      else if (carry_we) carry_q <= carry_nxt;
   end

   // R8
   carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_we |=> $stable(carry_q));

   // R4
   cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_CMP) |-> (!res_we && carry_we));

   // R3
   and_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_AND) |=> !carry_q);

   // R7
   scf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_SCF) |=> carry_q);

   // R7
   ccf_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_CCF) |=> (carry_q != $past(carry_q)));

   // R6
   incdec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=> $stable(carry_q));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (!res_we && !carry_we));

endmodule

// File: tb/test_acc_alu_unit.sv
module test_acc_alu_unit;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       op_valid;
   logic [3:0] op_code;
   logic [7:0] acc_in;
   logic [7:0] opnd_in;
   logic [7:0] res_out;
   logic       res_we;
   logic       carry_nxt;
   logic       carry_we;
   logic       carry_q;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   acc_alu_unit i_acc_alu_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .acc_in    (acc_in),
      .opnd_in   (opnd_in),
      .res_out   (res_out),
      .res_we    (res_we),
      .carry_nxt (carry_nxt),
      .carry_we  (carry_we),
      .carry_q   (carry_q)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (op %0d a %0d b %0d)",
                  tag, what, act, exp, op_code, acc_in, opnd_in);
      end
   endtask

   // Expected behaviour from the requirements
   task automatic model(input int op, input int a, input int b, input int c,
                        output bit wr, output int r, output bit wc, output bit cn,
                        output string tag);
      int s;
      wr = 0; r = 0; wc = 0; cn = c[0]; tag = "R9";
      case (op)
         0: begin s = a + b;     wr = 1; wc = 1; r = s & 255; cn = (s > 255); tag = "R1"; end
         1: begin s = a + b + c; wr = 1; wc = 1; r = s & 255; cn = (s > 255); tag = "R1"; end
         2: begin s = a - b;     wr = 1; wc = 1; r = s & 255; cn = (s < 0);   tag = "R2"; end
         3: begin s = a - b - c; wr = 1; wc = 1; r = s & 255; cn = (s < 0);   tag = "R2"; end
         4: begin wr = 1; wc = 1; r = a & b; cn = 0; tag = "R3"; end
         5: begin wc = 1; cn = (a < b); tag = "R4"; end
         6: begin wr = 1; r = a ^ 255; tag = "R5"; end
         7: begin wr = 1; r = (b + 1) & 255; tag = "R6"; end
         8: begin wr = 1; r = (b + 255) & 255; tag = "R6"; end
         9: begin wc = 1; cn = !c[0]; tag = "R7"; end
         10: begin wc = 1; cn = 1; tag = "R7"; end
         default: ;
      endcase
   endtask

   task automatic force_carry(input bit c);
      @(negedge clk);
      op_valid = 1'b1;
      op_code  = c ? 4'd10 : 4'd4;
      acc_in   = 8'h00;
      opnd_in  = 8'h00;
      @(posedge clk);
      #1;
      op_valid = 1'b0;
      check(c ? "R7" : "R3", "carry_q after set/clear", carry_q, c);
   endtask

   initial begin
      #700000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit    wr, wc, cn;
      int    r;
      string tag;
      rst_n    = 1'b0;
      op_valid = 1'b0;
      op_code  = 4'd0;
      acc_in   = 8'h00;
      opnd_in  = 8'h00;
      repeat (3) @(posedge clk);
      #1;
      // R8 reset value
      check("R8", "carry_q in reset", carry_q, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Combinational sweep with op_valid low, both carry states
      for (int c = 0; c < 2; c++) begin
         force_carry(c[0]);
         for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
               for (int j = 0; j < 32; j++) begin
                  int b = (j < 16) ? j : 224 + j;
                  op_code = op[3:0];
                  acc_in  = a[7:0];
                  opnd_in = b[7:0];
                  #1;
                  model(op, a, b, c, wr, r, wc, cn, tag);
                  if (wr) check(tag, "res_out", res_out, r);
                  if (wc) check(tag, "carry_nxt", carry_nxt, cn);
                  if (j == 0 && a == 0) begin
                     // R9 enables stay low while idle
                     check("R9", "res_we idle", res_we, 0);
                     check("R9", "carry_we idle", carry_we, 0);
                  end
               end
            end
         end
         @(negedge clk);
         // R8 idle sweep left carry untouched
         check("R8", "carry_q after idle sweep", carry_q, c);
      end

      // Issued operations: enables and carry register update
      for (int c = 0; c < 2; c++) begin
         for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 4; k++) begin
               int a = (k == 0) ? 8'hFF : (k == 1) ? 8'h00 : (k == 2) ? 8'h80 : 8'h3C;
               int b = (k == 0) ? 8'h01 : (k == 1) ? 8'h01 : (k == 2) ? 8'h80 : 8'h3C;
               force_carry(c[0]);
               @(negedge clk);
               op_valid = 1'b1;
               op_code  = op[3:0];
               acc_in   = a[7:0];
               opnd_in  = b[7:0];
               #1;
               model(op, a, b, c, wr, r, wc, cn, tag);
               check("R9", "res_we issued", res_we, wr);
               check("R9", "carry_we issued", carry_we, wc);
               if (wr) check(tag, "res_out issued", res_out, r);
               @(posedge clk);
               #1;
               op_valid = 1'b0;
               check(wc ? tag : "R8", "carry_q after op", carry_q, wc ? cn : c);
            end
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule